// File: doc/BRIEF.md
# Per-Hart Debug Privilege Policy Unit

This unit decides, for one hart, how far an external debugger may reach. It combines two security controls: a machine-level debug-enable state held inside the unit, and a supervisor-domain debug-allow bit taken from the hart's security configuration register. From these it derives the set of privilege levels that may be debugged, the highest debug access privilege the debugger may hold, and whether debug operations are permitted in the mode the hart is running now.

The unit also stores the debugger's requested access privilege, clamped to what policy allows. It holds a debug-entry request until the hart is in a mode where debug is allowed, and it produces the interrupt mask applied while single-stepping. That mask reaches only interrupts delegated to the supervisor domain when machine-level debug is off. A flag tells the abstract-command path whether commands issued without halting may carry machine privilege.

Top module: `dbg_priv_policy`

## Requirements
- R1: After reset the enable state is 0, the stored access privilege is U (0), no level is allowed, no error, no debug entry and no interrupt is masked.
- R2: With the enable state at 1, all five levels are allowed (`allow_o` = 5'b11111, bit order U, S, VU, VS, M from bit 0), and debug operations are permitted in every mode.
- R3: With the enable state at 0 and the supervisor allow bit at 1, every level except M is allowed (`allow_o` = 5'b01111), and operations are refused only while `cur_prv_i` is M (3).
- R4: With the enable state and the supervisor allow bit both 0, `allow_o` is 0 and debug operations are refused in every mode.
- R5: On an access request the stored privilege becomes the request clamped to the maximum (M=3 when enabled, S=1 when only supervisor allowed), with the reserved code 2 read as S. It is visible the next cycle, and `acc_prv_o` is re-clamped at once whenever the maximum falls.
- R6: An access request made while nothing is allowed leaves the stored privilege unchanged and raises `acc_err_o` for exactly the next cycle.
- R7: While stepping with step interrupt-disable set and the enable state at 1, every bit of `irq_mask_o` is 1.
- R8: While stepping with step interrupt-disable set, enable state 0 and supervisor allow 1, `irq_mask_o` equals `irq_deleg_i`, so interrupts that trap to M stay unmasked. With both controls 0, or when not stepping with the disable set, the mask is 0.
- R9: `absc_mprv_o`, the machine-privilege flag for non-halting abstract commands, equals the enable state.
- R10: A pulse on `mdbg_ld_i` loads `mdbg_val_i` into the enable state. The new value governs all outputs from the next cycle on and is held until the next load.
- R11: A debug-entry request made in a disallowed mode is held pending. `halt_o` pulses for one cycle in the first cycle, at least one cycle after the request, in which the current mode is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdbg_ld_i | input | 1 | Load strobe for the machine debug-enable state |
| mdbg_val_i | input | 1 | Value loaded on the strobe |
| sd_dbg_alw_i | input | 1 | Supervisor-domain debug-allow bit from the security configuration |
| cur_prv_i | input | 2 | Current privilege: U=0, S=1, M=3 (2 treated as U) |
| cur_virt_i | input | 1 | Hart runs virtualized (VS/VU when not M) |
| acc_req_i | input | 1 | Debugger writes a new access privilege |
| acc_prv_req_i | input | 2 | Requested access privilege |
| halt_req_i | input | 1 | Debug-entry request pulse |
| step_i | input | 1 | Hart is single-stepping |
| step_irq_dis_i | input | 1 | Step interrupt-disable control |
| irq_deleg_i | input | NIRQ | Per-interrupt: 1 = delegated to the supervisor domain |
| allow_o | output | 5 | Allowed levels: bit0 U, bit1 S, bit2 VU, bit3 VS, bit4 M |
| acc_prv_o | output | 2 | Effective debug access privilege |
| acc_err_o | output | 1 | Rejected access request (one cycle) |
| dbg_op_ok_o | output | 1 | Debug operations permitted in the current mode |
| absc_mprv_o | output | 1 | Non-halting abstract commands carry M privilege |
| halt_o | output | 1 | Debug-entry released to the hart (one-cycle pulse) |
| irq_mask_o | output | NIRQ | Interrupts masked during the step |

## Verification
The hardest situation to reach is a stored access privilege of M followed by a drop of the enable state. The output must then fall to S, or to U if nothing is allowed, without a new request. A second hard case is a pending debug entry that outlives several mode changes before it is released. Random stimulus reaches both by loading the enable state rarely while requests and mode changes are frequent. Directed sequences add the exact M-then-drop case and a long wait in M before a move into S.

// File: rtl/dbg_priv_pkg.sv
package dbg_priv_pkg;
  localparam int unsigned PRV_W = 2;
  localparam int unsigned LVL_N = 5;

  localparam logic [PRV_W-1:0] PRV_U = 2'd0;
  localparam logic [PRV_W-1:0] PRV_S = 2'd1;
  localparam logic [PRV_W-1:0] PRV_R = 2'd2;
  localparam logic [PRV_W-1:0] PRV_M = 2'd3;

  typedef enum logic [2:0] {
    LVL_U  = 3'd0,
    LVL_S  = 3'd1,
    LVL_VU = 3'd2,
    LVL_VS = 3'd3,
    LVL_M  = 3'd4
  } lvl_e;

  // reserved privilege code is read as S
  function automatic logic [PRV_W-1:0] prv_legal(input logic [PRV_W-1:0] p);
    return (p == PRV_R) ? PRV_S : p;
  endfunction
endpackage

// File: rtl/dbg_en_reg.sv
module dbg_en_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic val_i,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= 1'b0;
    else if (ld_i) en_o <= val_i;
  end

  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> en_o == $past(val_i)); // R10
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(en_o)); // R10
endmodule

// File: rtl/dbg_priv_decode.sv
module dbg_priv_decode
  import dbg_priv_pkg::*;
(
  input  logic             en_i,
  input  logic             sd_alw_i,
  input  logic [PRV_W-1:0] cur_prv_i,
  input  logic             cur_virt_i,
  output logic [LVL_N-1:0] allow_o,
  output logic [PRV_W-1:0] max_prv_o,
  output logic             none_o,
  output logic             cur_ok_o
);
  logic sd_ok;
  lvl_e cur_lvl;

  assign sd_ok = en_i | sd_alw_i;

  always_comb begin
    allow_o         = '0;
    allow_o[LVL_U]  = sd_ok;
    allow_o[LVL_S]  = sd_ok;
    allow_o[LVL_VU] = sd_ok;
    allow_o[LVL_VS] = sd_ok;
    allow_o[LVL_M]  = en_i;
  end

  always_comb begin
    if (en_i)          max_prv_o = PRV_M;
    else if (sd_alw_i) max_prv_o = PRV_S;
    else               max_prv_o = PRV_U;
  end

  assign none_o = ~sd_ok;

  always_comb begin
    if (cur_prv_i == PRV_M)      cur_lvl = LVL_M;
    else if (cur_prv_i == PRV_S) cur_lvl = cur_virt_i ? LVL_VS : LVL_S;
    else                         cur_lvl = cur_virt_i ? LVL_VU : LVL_U;
  end

  assign cur_ok_o = allow_o[cur_lvl];
endmodule

// File: rtl/dbg_acc_clamp.sv
module dbg_acc_clamp
  import dbg_priv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [PRV_W-1:0] req_prv_i,
  input  logic [PRV_W-1:0] max_prv_i,
  input  logic             none_i,
  output logic [PRV_W-1:0] acc_prv_o,
  output logic             err_o
);
  logic [PRV_W-1:0] acc_q, req_l, req_c;

  assign req_l = prv_legal(req_prv_i);
  assign req_c = (req_l > max_prv_i) ? max_prv_i : req_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= PRV_U;
      err_o <= 1'b0;
    end else begin
      err_o <= req_i & none_i;
      if (req_i && !none_i) acc_q <= req_c;
    end
  end

  // follow a shrinking policy without a new request
  always_comb begin
    if (none_i)                 acc_prv_o = PRV_U;
    else if (acc_q > max_prv_i) acc_prv_o = max_prv_i;
    else                        acc_prv_o = acc_q;
  end

  AST_ACC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !none_i |-> acc_prv_o <= max_prv_i); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i)); // R6
endmodule

// File: rtl/dbg_irq_mask.sv
module dbg_irq_mask #(
  parameter int unsigned NIRQ = 16
) (
  input  logic            en_i,
  input  logic            sd_alw_i,
  input  logic            step_i,
  input  logic            dis_i,
  input  logic [NIRQ-1:0] deleg_i,
  output logic [NIRQ-1:0] mask_o
);
  logic act;
  assign act = step_i & dis_i;

  for (genvar g = 0; g < NIRQ; g++) begin : g_irq
    assign mask_o[g] = act & (en_i | (sd_alw_i & deleg_i[g]));
  end
endmodule

// File: rtl/dbg_halt_gate.sv
module dbg_halt_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ok_i,
  output logic halt_o
);
  logic pend_q;

  assign halt_o = pend_q & ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~halt_o) | req_i;
  end

  AST_HALT_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !req_i |=> !halt_o); // R11
endmodule

// File: rtl/dbg_priv_policy.sv
module dbg_priv_policy
  import dbg_priv_pkg::*;
#(
  parameter int unsigned NIRQ = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mdbg_ld_i,
  input  logic             mdbg_val_i,
  input  logic             sd_dbg_alw_i,
  input  logic [1:0]       cur_prv_i,
  input  logic             cur_virt_i,
  input  logic             acc_req_i,
  input  logic [1:0]       acc_prv_req_i,
  input  logic             halt_req_i,
  input  logic             step_i,
  input  logic             step_irq_dis_i,
  input  logic [NIRQ-1:0]  irq_deleg_i,
  output logic [4:0]       allow_o,
  output logic [1:0]       acc_prv_o,
  output logic             acc_err_o,
  output logic             dbg_op_ok_o,
  output logic             absc_mprv_o,
  output logic             halt_o,
  output logic [NIRQ-1:0]  irq_mask_o
);
  logic             en_q;
  logic [PRV_W-1:0] max_prv;
  logic             none;

  dbg_en_reg u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (mdbg_ld_i),
    .val_i (mdbg_val_i),
    .en_o  (en_q)
  );

  dbg_priv_decode u_dec (
    .en_i      (en_q),
    .sd_alw_i  (sd_dbg_alw_i),
    .cur_prv_i (cur_prv_i),
    .cur_virt_i(cur_virt_i),
    .allow_o   (allow_o),
    .max_prv_o (max_prv),
    .none_o    (none),
    .cur_ok_o  (dbg_op_ok_o)
  );

  dbg_acc_clamp u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (acc_req_i),
    .req_prv_i(acc_prv_req_i),
    .max_prv_i(max_prv),
    .none_i   (none),
    .acc_prv_o(acc_prv_o),
    .err_o    (acc_err_o)
  );

  dbg_irq_mask #(.NIRQ(NIRQ)) u_irq (
    .en_i    (en_q),
    .sd_alw_i(sd_dbg_alw_i),
    .step_i  (step_i),
    .dis_i   (step_irq_dis_i),
    .deleg_i (irq_deleg_i),
    .mask_o  (irq_mask_o)
  );

  dbg_halt_gate u_halt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (halt_req_i),
    .ok_i  (dbg_op_ok_o),
    .halt_o(halt_o)
  );

  assign absc_mprv_o = en_q;

  AST_M_IMPLIES_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o[LVL_M] |-> &allow_o); // R2
  AST_NONE_NO_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o == '0 |-> !dbg_op_ok_o && !halt_o); // R4
  AST_MASK_SD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_o[LVL_M] |-> (irq_mask_o & ~irq_deleg_i) == '0); // R8
  AST_M_MODE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_prv_i == PRV_M && !absc_mprv_o |-> !dbg_op_ok_o); // R3
endmodule

// File: tb/dbg_priv_policy_tb_top.sv
module dbg_priv_policy_tb_top;
  localparam int unsigned NIRQ = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mdbg_ld_i = 0, mdbg_val_i = 0, sd_dbg_alw_i = 0, cur_virt_i = 0;
  logic [1:0] cur_prv_i = 0, acc_prv_req_i = 0;
  logic acc_req_i = 0, halt_req_i = 0, step_i = 0, step_irq_dis_i = 0;
  logic [NIRQ-1:0] irq_deleg_i = '0;
  logic [4:0] allow_o;
  logic [1:0] acc_prv_o;
  logic acc_err_o, dbg_op_ok_o, absc_mprv_o, halt_o;
  logic [NIRQ-1:0] irq_mask_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  bit       en_m = 0, err_m = 0, pend_m = 0;
  bit [1:0] acc_m = 0;

  always #2 clk = ~clk;

  dbg_priv_policy #(.NIRQ(NIRQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mdbg_ld_i(mdbg_ld_i), .mdbg_val_i(mdbg_val_i),
    .sd_dbg_alw_i(sd_dbg_alw_i), .cur_prv_i(cur_prv_i), .cur_virt_i(cur_virt_i),
    .acc_req_i(acc_req_i), .acc_prv_req_i(acc_prv_req_i), .halt_req_i(halt_req_i),
    .step_i(step_i), .step_irq_dis_i(step_irq_dis_i), .irq_deleg_i(irq_deleg_i),
    .allow_o(allow_o), .acc_prv_o(acc_prv_o), .acc_err_o(acc_err_o),
    .dbg_op_ok_o(dbg_op_ok_o), .absc_mprv_o(absc_mprv_o), .halt_o(halt_o),
    .irq_mask_o(irq_mask_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [1:0] max_of(input bit en, input bit sd);
    return en ? 2'd3 : (sd ? 2'd1 : 2'd0);
  endfunction

  function automatic bit [1:0] legal(input bit [1:0] p);
    return (p == 2'd2) ? 2'd1 : p;
  endfunction

  task automatic cyc(input bit ld, input bit lv, input bit sd, input bit [1:0] prv,
                     input bit virt, input bit av, input bit [1:0] ap, input bit hr,
                     input bit st, input bit dis, input bit [NIRQ-1:0] dg);
    bit [1:0] mx, ea, lc;
    bit none, ok, eh;
    bit [4:0] eall;
    bit [NIRQ-1:0] em;
    @(negedge clk);
    mdbg_ld_i = ld; mdbg_val_i = lv; sd_dbg_alw_i = sd; cur_prv_i = prv;
    cur_virt_i = virt; acc_req_i = av; acc_prv_req_i = ap; halt_req_i = hr;
    step_i = st; step_irq_dis_i = dis; irq_deleg_i = dg;
    #1;
    mx   = max_of(en_m, sd);
    none = !(en_m | sd);
    eall = {en_m, {4{en_m | sd}}};
    ok   = (prv == 2'd3) ? en_m : (en_m | sd);
    ea   = none ? 2'd0 : ((acc_m > mx) ? mx : acc_m);
    eh   = pend_m & ok;
    em   = (st & dis) ? (en_m ? '1 : (sd ? dg : '0)) : '0;
    chk(en_m ? "R2 allow" : (sd ? "R3 allow" : "R4 allow"), 32'(allow_o), 32'(eall));
    chk(en_m ? "R2 op_ok" : (sd ? "R3 op_ok" : "R4 op_ok"), 32'(dbg_op_ok_o), 32'(ok));
    chk("R5 acc_prv", 32'(acc_prv_o), 32'(ea));
    chk("R6 acc_err", 32'(acc_err_o), 32'(err_m));
    chk(en_m ? "R7 mask" : "R8 mask", 32'(irq_mask_o), 32'(em));
    chk("R9 absc", 32'(absc_mprv_o), 32'(en_m));
    chk("R11 halt", 32'(halt_o), 32'(eh));
    // model update at the coming edge
    err_m = av & none;
    lc = legal(ap);
    if (av && !none) acc_m = (lc > mx) ? mx : lc;
    pend_m = (pend_m & !eh) | hr;
    if (ld) en_m = lv;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 allow", 32'(allow_o), 0);
    chk("R1 acc_prv", 32'(acc_prv_o), 0);
    chk("R1 err", 32'(acc_err_o), 0);
    chk("R1 halt", 32'(halt_o), 0);
    chk("R1 absc", 32'(absc_mprv_o), 0);
    rst_ni = 1'b1;

    // R4/R6: nothing allowed, request rejected, halt held in M
    cyc(0,0,0,2'd3,0, 1,2'd3, 1, 1,1,16'hFFFF);
    cyc(0,0,0,2'd3,0, 0,2'd0, 0, 1,1,16'hFFFF);
    chk("R6 err pulse", 32'(acc_err_o), 1);
    cyc(0,0,0,2'd1,0, 0,2'd0, 0, 0,0,'0);
    chk("R6 err single", 32'(acc_err_o), 0);
    // R11: allow supervisor, hart in M: still pending, then move to S
    cyc(0,0,1,2'd3,0, 0,2'd0, 0, 0,0,'0);
    cyc(0,0,1,2'd3,0, 0,2'd0, 0, 0,0,'0);
    chk("R11 held in M", 32'(halt_o), 0);
    cyc(0,0,1,2'd1,1, 0,2'd0, 0, 0,0,'0);
    chk("R11 released in VS", 32'(halt_o), 1);
    cyc(0,0,1,2'd1,1, 0,2'd0, 0, 0,0,'0);
    chk("R11 one pulse", 32'(halt_o), 0);
    // R10: load enable, seen next cycle
    cyc(1,1,0,2'd3,0, 0,2'd0, 0, 0,0,'0);
    chk("R10 not yet", 32'(allow_o[4]), 0);
    cyc(0,0,0,2'd3,0, 1,2'd3, 0, 1,1,16'h00F0);
    chk("R10 active", 32'(allow_o[4]), 1);
    chk("R7 all masked", 32'(irq_mask_o), 32'hFFFF);
    // R5: stored M, policy drops to supervisor only -> S
    cyc(1,0,1,2'd0,0, 0,2'd0, 0, 0,0,'0);
    chk("R5 stored M", 32'(acc_prv_o), 3);
    cyc(0,0,1,2'd0,0, 0,2'd0, 0, 1,1,16'h00F0);
    chk("R5 reclamp S", 32'(acc_prv_o), 1);
    chk("R8 deleg only", 32'(irq_mask_o), 32'h00F0);
    cyc(0,0,0,2'd0,0, 0,2'd0, 0, 1,1,16'h00F0);
    chk("R5 reclamp none", 32'(acc_prv_o), 0);
    chk("R8 none masked", 32'(irq_mask_o), 0);
    cyc(0,0,1,2'd0,0, 1,2'd2, 0, 0,0,'0);
    cyc(0,0,1,2'd0,0, 0,2'd0, 0, 0,0,'0);
    chk("R5 reserved as S", 32'(acc_prv_o), 1);

    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 16) == 0, $urandom % 2, $urandom % 2, 2'($urandom),
          $urandom % 2, ($urandom % 4) == 0, 2'($urandom), ($urandom % 8) == 0,
          $urandom % 2, $urandom % 2, NIRQ'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule